// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the slave-side command decoder that protects the status register of a serial flash. It watches a serial command stream framed by an active-low chip select. Opcodes and data arrive most significant bit first and are sampled on rising serial-clock edges. Both idle-low and idle-high clock polarities (SPI modes 0 and 3) work without configuration. Each instruction takes effect only when chip select returns high, and only if the frame holds a whole number of bytes.

A write to the status register needs an arming instruction in the frame directly before it. The arming instruction is either the status-write enable or the general write enable. The write then passes a protection rule. A lock bit and a write-protect input pin are sampled as chip select returns high. These two values decide whether the write is dropped, whether it may only set the lock, or whether it may change every writable bit. A read-status command returns the register byte on the serial output, and the output-enable marks the only cycles in which that output is driven.

The serial pins are expected to be synchronous to the block clock, which runs several times faster than the serial clock. Edges are found by comparing each pin with its registered copy.

Top module: `spi_sr_guard`

## Requirements
- R1: The bits on `si` are sampled on rising `sck` edges while `cs_n` is low, most significant bit first. `sck` may idle low or idle high when `cs_n` falls.
- R2: A frame acts only at the rising edge of `cs_n`. A frame of zero bits, or of a bit count that is not a multiple of 8, is discarded and changes neither the register nor the armed state.
- R3: A frame of exactly 8 bits holding opcode 0x50 or 0x06 arms the next instruction. Every other whole-byte frame leaves the block disarmed, and this includes the write-status frame itself and a longer frame that begins with an arming opcode.
- R4: Write-status is opcode 0x01 followed by exactly one data byte (16 bits in all). When it is armed and allowed, data bit 7 goes to the lock bit (status bit 7) and data bits 5..2 go to the protect field (status bits 5..2). Data bits 6, 1 and 0 have no effect. When it is unarmed, the register does not change.
- R5: When `wp_n` is 0 and the lock bit is 1, an armed write-status frame leaves the lock bit and the protect field unchanged.
- R6: When `wp_n` is 0 and the lock bit is 0, a single write-status frame may set the lock bit and change the protect field together.
- R7: When `wp_n` is 1, the lock has no effect, and a write-status frame may clear the lock bit as well as change the protect field.
- R8: The levels of `wp_n` and of the lock bit used by the rule are those present when `cs_n` rises at the end of the frame. The level of `wp_n` while the bits are shifted does not matter.
- R9: Status bit 1 (write-enable latch) is set by an 8-bit 0x06 frame. It is not changed by 0x50. It is cleared by every 16-bit write-status frame, whether the write is applied or not. Status bits 0 and 6 always read 0.
- R10: After the 8 bits of opcode 0x05, each falling `sck` edge presents the next status bit on `so_data`, starting with bit 7. The byte repeats for as long as clocking continues. `so_en` is 1 only from that first falling edge until `cs_n` rises.
- R11: After reset, `status` is 0x3C: protect field all ones, lock bit 0, write-enable latch 0. The block is disarmed and `so_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select that frames each instruction |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-protect pin |
| so_data | output | 1 | Serial data out for the read-status response |
| so_en | output | 1 | Drive enable for `so_data`; when it is 0 the pad floats |
| status | output | 8 | Current status register value |

## Verification
The hardest cases to reach are the ones where the decision depends on levels that exist only at the closing edge of chip select. One is a `wp_n` that changes between the last data bit and the release of `cs_n`. Another is an arming frame that survives a discarded partial frame in between. The bench's transfer task takes separate `wp_n` levels for the shifting phase and for the release. It also accepts any bit count, including 0, 5 and 15, so these sequences can be built straight from the ports. Each table vector is then read back through the serial read-status command, which covers the output path as well.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int BYTE_W = 8;
  localparam int BP_W   = 4;
  localparam int BP_LO  = 2;
  localparam int LOCK_BIT = 7;
  localparam int WEL_BIT  = 1;

  localparam logic [BYTE_W-1:0] OP_EWSR = 8'h50;
  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;

  localparam logic [BP_W-1:0] BP_RESET = '1;

  // Protection rule: a write may proceed unless the pin is low and the lock is set.
  function automatic logic wr_allowed(input logic wp_n, input logic lock);
    return wp_n | ~lock;
  endfunction

  // Writable fields carried by the data byte: {lock, protect}.
  function automatic logic [BP_W:0] wr_fields(input logic [BYTE_W-1:0] dat);
    return {dat[LOCK_BIT], dat[BP_LO+BP_W-1:BP_LO]};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic lock,
                                                    input logic [BP_W-1:0] bp,
                                                    input logic wel);
    return {lock, 1'b0, bp, wel, 1'b0};
  endfunction
endpackage

// File: rtl/spi_sr_shifter.sv
module spi_sr_shifter
  import spi_sr_pkg::*;
#(
  parameter int W     = BYTE_W,
  localparam int PW   = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sck,
  input  logic         si,
  output logic         sck_fall,
  output logic         frame_done,
  output logic         frame_whole,
  output logic [1:0]   frame_bytes,
  output logic [W-1:0] op_q,
  output logic [W-1:0] dat_q
);
  logic          sck_q, cs_q;
  logic [PW-1:0] bitpos;
  logic [1:0]    nbytes;
  logic [W-1:0]  sh;
  logic [W-1:0]  sh_nxt;
  logic          sck_rise;

  assign sck_rise    = ~cs_n & sck & ~sck_q;
  assign sck_fall    = ~cs_n & ~sck & sck_q;
  assign sh_nxt      = {sh[W-2:0], si};
  assign frame_done  = cs_n & ~cs_q;
  assign frame_whole = (bitpos == '0) && (nbytes != 2'd0);
  assign frame_bytes = nbytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitpos <= '0;
      nbytes <= 2'd0;
      sh     <= '0;
      op_q   <= '0;
      dat_q  <= '0;
    end else if (cs_n) begin
      bitpos <= '0;
      nbytes <= 2'd0;
    end else if (sck_rise) begin
      sh <= sh_nxt;
      if (bitpos == PW'(W-1)) begin
        bitpos <= '0;
        if (nbytes == 2'd0) op_q  <= sh_nxt;
        if (nbytes == 2'd1) dat_q <= sh_nxt;
        if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
      end else begin
        bitpos <= bitpos + PW'(1);
      end
    end
  end

  // R2: a frame is reported only at the release of chip select
  p_frame_at_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (cs_n && !$past(cs_n)));
endmodule

// File: rtl/spi_sr_guard_core.sv
module spi_sr_guard_core
  import spi_sr_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wp_n,
  input  logic         frame_done,
  input  logic         frame_whole,
  input  logic [1:0]   frame_bytes,
  input  logic [W-1:0] op_q,
  input  logic [W-1:0] dat_q,
  output logic [W-1:0] status,
  output logic         armed
);
  logic            lock;
  logic [BP_W-1:0] bp;
  logic            wel;
  logic            ev_valid, ev_arm, ev_wrsr, ev_write;
  logic [BP_W:0]   new_fields;

  assign ev_valid   = frame_done & frame_whole;
  assign ev_arm     = ev_valid && (frame_bytes == 2'd1) &&
                      ((op_q == OP_EWSR) || (op_q == OP_WREN));
  assign ev_wrsr    = ev_valid && (frame_bytes == 2'd2) && (op_q == OP_WRSR);
  assign ev_write   = ev_wrsr && armed && wr_allowed(wp_n, lock);
  assign new_fields = wr_fields(dat_q);
  assign status     = pack_status(lock, bp, wel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      wel   <= 1'b0;
      lock  <= 1'b0;
      bp    <= BP_RESET;
    end else if (ev_valid) begin
      armed <= ev_arm;
      if (ev_arm && (op_q == OP_WREN)) wel <= 1'b1;
      if (ev_wrsr) wel <= 1'b0;
      if (ev_write) {lock, bp} <= new_fields;
    end
  end

  // R3: any whole frame other than an arming one leaves the block disarmed
  p_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_arm) |=> !armed);
  // R4: an unarmed write-status frame leaves the writable fields alone
  p_unarmed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrsr && !armed) |=> (status[7:2] == $past(status[7:2])));
  // R5: a locked register with the pin low is not altered
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrsr && !wp_n && status[LOCK_BIT]) |=> $stable(status[7:2]));
  // R7: the lock bit can only be cleared while the pin is high
  p_unlock_needs_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[LOCK_BIT]) |-> $past(wp_n));
  // R9: bits 0 and 6 never read as 1
  p_fixed_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] == 1'b0) && (status[6] == 1'b0));
endmodule

// File: rtl/spi_sr_readout.sv
module spi_sr_readout
  import spi_sr_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sck_fall,
  input  logic         op_ready,
  input  logic         op_is_read,
  input  logic [W-1:0] status,
  output logic         so_data,
  output logic         so_en
);
  logic [W-1:0] shr;
  logic         active;

  assign so_data = shr[W-1];
  assign so_en   = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      shr    <= '0;
    end else if (cs_n) begin
      active <= 1'b0;
    end else if (sck_fall) begin
      if (active) begin
        shr <= {shr[W-2:0], shr[W-1]};
      end else if (op_ready && op_is_read) begin
        active <= 1'b1;
        shr    <= status;
      end
    end
  end

  // R10: the output is driven only inside a selected frame
  p_so_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    so_en |-> !$past(cs_n));
endmodule

// File: rtl/spi_sr_guard.sv
module spi_sr_guard
  import spi_sr_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sck,
  input  logic         si,
  input  logic         wp_n,
  output logic         so_data,
  output logic         so_en,
  output logic [W-1:0] status
);
  logic         sck_fall, frame_done, frame_whole, armed;
  logic [1:0]   frame_bytes;
  logic [W-1:0] op_q, dat_q;

  spi_sr_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .sck_fall(sck_fall), .frame_done(frame_done), .frame_whole(frame_whole),
    .frame_bytes(frame_bytes), .op_q(op_q), .dat_q(dat_q)
  );

  spi_sr_guard_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .frame_done(frame_done),
    .frame_whole(frame_whole), .frame_bytes(frame_bytes), .op_q(op_q),
    .dat_q(dat_q), .status(status), .armed(armed)
  );

  spi_sr_readout #(.W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_fall(sck_fall),
    .op_ready(frame_bytes != 2'd0), .op_is_read(op_q == OP_RDSR),
    .status(status), .so_data(so_data), .so_en(so_en)
  );

  // R11: nothing is armed in the cycle after reset is released
  p_reset_disarmed_r11: assert property (@(posedge clk)
    $rose(rst_n) |-> !armed);
endmodule

// File: tb/tb_spi_sr_guard.sv
module tb_spi_sr_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so_data, so_en;
  logic [7:0] status;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  spi_sr_guard dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
                    .wp_n(wp_n), .so_data(so_data), .so_en(so_en), .status(status));

  // {arming opcode (0 = none), wp_n, data byte, expected status}
  localparam logic [31:0] VEC [12] = '{
    {8'h50, 8'h01, 8'h00, 8'h00},
    {8'h06, 8'h01, 8'hBC, 8'hBC},
    {8'h50, 8'h00, 8'h00, 8'hBC},
    {8'h06, 8'h00, 8'h80, 8'hBC},
    {8'h50, 8'h01, 8'h14, 8'h14},
    {8'h50, 8'h00, 8'h88, 8'h88},
    {8'h50, 8'h01, 8'h7F, 8'h3C},
    {8'h00, 8'h01, 8'h00, 8'h3C},
    {8'h05, 8'h01, 8'h00, 8'h3C},
    {8'h9F, 8'h01, 8'h04, 8'h3C},
    {8'h06, 8'h00, 8'h20, 8'h20},
    {8'h50, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift nbits of word (from bit 23 down); sample so_data after each falling edge.
  task automatic xfer(input int nbits, input logic [23:0] word, input bit m3,
                      input logic wp_shift, input logic wp_end,
                      output logic [23:0] cap);
    cap = '0;
    wp_n = wp_shift;
    sck = m3;
    wclk(2);
    cs_n = 1'b0;
    wclk(3);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      si = word[23-i];
      wclk(3);
      cap[23-i] = so_data;
      sck = 1'b1;
      wclk(3);
    end
    if (!m3) begin
      sck = 1'b0;
      wclk(2);
    end
    wp_n = wp_end;
    wclk(2);
    cs_n = 1'b1;
    wclk(3);
  endtask

  task automatic cmd(input logic [7:0] op, input logic w);
    logic [23:0] c;
    xfer(8, {op, 16'h0}, 1'b0, w, w, c);
  endtask

  task automatic wrsr(input logic [7:0] d, input logic w);
    logic [23:0] c;
    xfer(16, {8'h01, d, 8'h0}, 1'b1, w, w, c);
  endtask

  task automatic rdsr(input bit m3, output logic [7:0] b);
    logic [23:0] c;
    xfer(16, {8'h05, 16'h0}, m3, wp_n, wp_n, c);
    b = c[15:8];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rb;
    logic [23:0] c;
    wclk(4);
    chk("R11 reset status", {8'h0, status}, 16'h003C);
    chk("R11 reset so_en", {15'h0, so_en}, 16'h0);
    rst_n = 1'b1;
    wclk(3);
    chk("R11 status after release", {8'h0, status}, 16'h003C);

    // Table: R1 R3 R4 R5 R6 R7, each vector read back through R10
    for (int v = 0; v < 12; v++) begin
      logic [31:0] e;
      e = VEC[v];
      if (e[31:24] != 8'h00) xfer(8, {e[31:24], 16'h0}, v[0], e[16], e[16], c);
      xfer(16, {8'h01, e[15:8], 8'h0}, ~v[0], e[16], e[16], c);
      chk($sformatf("R4/R5/R6/R7 vector %0d port", v), {8'h0, status}, {8'h0, e[7:0]});
      rdsr(v[1], rb);
      chk($sformatf("R10/R1 vector %0d readback", v), {8'h0, rb}, {8'h0, e[7:0]});
    end

    // R9 write-enable latch
    cmd(8'h06, 1'b1);
    chk("R9 WEL set by 0x06", {8'h0, status}, 16'h0002);
    cmd(8'h50, 1'b1);
    chk("R9 WEL kept by 0x50", {8'h0, status}, 16'h0002);
    rdsr(1'b0, rb);
    chk("R10 readback shows WEL", {8'h0, rb}, 16'h0002);
    wrsr(8'h3C, 1'b1);
    chk("R9/R4 unarmed write clears WEL only", {8'h0, status}, 16'h0000);

    // R2 discarded frames keep the arm
    cmd(8'h50, 1'b1);
    xfer(5, 24'hF80000, 1'b0, 1'b1, 1'b1, c);
    xfer(0, 24'h0, 1'b1, 1'b1, 1'b1, c);
    wrsr(8'h3C, 1'b1);
    chk("R2 arm survives 5-bit and empty frames", {8'h0, status}, 16'h003C);
    cmd(8'h06, 1'b1);
    xfer(15, 24'h010000, 1'b0, 1'b1, 1'b1, c);
    chk("R2 15-bit write-status discarded", {8'h0, status}, 16'h003E);
    wrsr(8'h00, 1'b1);
    chk("R2 arm kept after partial write", {8'h0, status}, 16'h0000);

    // R3 disarm by long arming frame and by a completed write
    xfer(16, {8'h50, 16'h0}, 1'b0, 1'b1, 1'b1, c);
    wrsr(8'h3C, 1'b1);
    chk("R3 16-bit 0x50 frame does not arm", {8'h0, status}, 16'h0000);
    cmd(8'h50, 1'b1);
    wrsr(8'h84, 1'b1);
    wrsr(8'h3C, 1'b1);
    chk("R3 second write without re-arm ignored", {8'h0, status}, 16'h0084);

    // R8 pin level taken at chip-select release
    cmd(8'h50, 1'b1);
    xfer(16, 24'h010400, 1'b1, 1'b0, 1'b1, c);
    chk("R8 pin raised before release allows write", {8'h0, status}, 16'h0004);
    cmd(8'h50, 1'b1);
    wrsr(8'h84, 1'b1);
    cmd(8'h50, 1'b1);
    xfer(16, 24'h010000, 1'b0, 1'b1, 1'b0, c);
    chk("R8/R5 pin lowered before release blocks write", {8'h0, status}, 16'h0084);

    // R10 repeated byte in both modes, output released afterwards
    wp_n = 1'b1;
    xfer(24, {8'h05, 16'h0}, 1'b0, 1'b1, 1'b1, c);
    chk("R10 mode 0 repeated byte", c[15:0], 16'h8484);
    chk("R10 so_en low after frame", {15'h0, so_en}, 16'h0);
    xfer(24, {8'h05, 16'h0}, 1'b1, 1'b1, 1'b1, c);
    chk("R10 mode 3 repeated byte", c[15:0], 16'h8484);
    xfer(8, {8'h06, 16'h0}, 1'b0, 1'b1, 1'b1, c);
    chk("R10 no output during non-read frame", {8'h0, c[23:16]}, 16'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule